// File: doc/BRIEF.md
# Timer Compare Channel Output Generator

This block is one compare channel of a general-purpose up-counting timer. It watches the running counter value and, according to a three-bit output mode, produces an output reference level. Four modes act on a compare match (hold, drive low, drive high, toggle). Two force a fixed level. Two are pulse-width modulation modes with opposite senses. The reference is active-high, and any polarity inversion is done outside the block.

The channel has a compare register that software writes and a shadow copy that the comparator reads. When preload is off, a write reaches the shadow at once. When preload is on, the shadow takes the register's value only on an update-event strobe. The compare value is one bit wider than the counter, so a value above every count is possible. The counter clock-enable qualifies every match and every modulation decision. The output is registered and changes on the clock edge after the cycle that decides it.

Top module: `tcc_top`

## Requirements
- R1: After reset the output reference is 0, the mode is 000 (hold), preload is off, and both the compare register and the shadow hold 0.
- R2: In mode 000 the output reference keeps its level, even on a qualified compare match.
- R3: A compare match is a cycle with `cnt_en` high and the zero-extended counter equal to the shadow. On a match, mode 001 drives the reference to 0 and mode 010 drives it to 1. Counter values that do not match, and matches with `cnt_en` low, have no effect.
- R4: In mode 011 the reference inverts once for each qualified match. It does not change when `cnt_en` is low or when the counter is not equal to the shadow.
- R5: Mode 100 drives the reference to 0 and mode 101 drives it to 1 on every clock, whatever `cnt_en` and the counter are.
- R6: In mode 110, on each cycle with `cnt_en` high, the reference becomes 1 if the counter is less than the shadow and 0 otherwise.
- R7: In mode 111, on each cycle with `cnt_en` high, the reference becomes 0 if the counter is less than the shadow and 1 otherwise.
- R8: With preload off (`cfg_preload`=0), a compare write appears in `cmp_active` on the next clock edge.
- R9: With preload on, a compare write updates `cmp_rdata` only. `cmp_active` keeps its value until an `upd_evt` cycle, which copies the compare register into it.
- R10: With preload on, if a compare write and `upd_evt` fall in the same cycle, the shadow loads the newly written value.
- R11: A mode change alone does not alter the reference. It keeps its level until the new mode next acts on it.
- R12: In the modulation modes, a shadow of 0 gives a constant level: 0 in mode 110 and 1 in mode 111. A shadow above the largest count (2^CNT_W or more) gives the opposite constant level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter clock-enable; qualifies compare evaluation |
| cnt_val | input | CNT_W | Running counter value |
| upd_evt | input | 1 | Update-event strobe |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W+1 | Compare value to write |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Output mode to write |
| cfg_preload | input | 1 | Preload enable to write |
| cmp_rdata | output | CNT_W+1 | Compare register value |
| cmp_active | output | CNT_W+1 | Shadow compare value used by the comparator |
| oref | output | 1 | Output reference level |

## Verification
Two events can fall in the same cycle: a compare-register write and an update event, with preload enabled. The bench drives `cmp_wr` and `upd_evt` together on one edge. It judges the result by reading `cmp_active` on the next cycle, which must hold the freshly written value and not the older register contents. It then repeats the pair in separate cycles. This shows that a write alone leaves the shadow unchanged, and that a later update copies the register into the shadow.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        OM_HOLD  = 3'b000,
        OM_CLR   = 3'b001,
        OM_SET   = 3'b010,
        OM_TGL   = 3'b011,
        OM_LOW   = 3'b100,
        OM_HIGH  = 3'b101,
        OM_PWM_A = 3'b110,
        OM_PWM_B = 3'b111
    } out_mode_e;

endpackage

// File: rtl/tcc_cfg_regs.sv
module tcc_cfg_regs
    import tcc_pkg::*;
#(
    parameter int CMP_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_evt,
    input  logic             cmp_wr,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_preload,
    output out_mode_e        mode,
    output logic [CMP_W-1:0] cmp_reg,
    output logic [CMP_W-1:0] cmp_shd
);

    typedef struct packed {
        out_mode_e        mode;
        logic             pre;
        logic [CMP_W-1:0] cmp;
        logic [CMP_W-1:0] shd;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.mode = out_mode_e'(cfg_mode);
            st_d.pre  = cfg_preload;
        end
        if (cmp_wr) begin
            st_d.cmp = cmp_wdata;
        end
        // Shadow follows the register directly, or on the update event when preloaded
        if (!st_q.pre) begin
            if (cmp_wr) begin
                st_d.shd = cmp_wdata;
            end else if (upd_evt) begin
                st_d.shd = st_q.cmp;
            end
        end else if (upd_evt) begin
            st_d.shd = cmp_wr ? cmp_wdata : st_q.cmp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: OM_HOLD, pre: 1'b0, cmp: '0, shd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.mode;
    assign cmp_reg = st_q.cmp;
    assign cmp_shd = st_q.shd;

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pre && cmp_wr) |=> (cmp_shd == $past(cmp_wdata))); // R8
    AST_PRELOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pre && !upd_evt) |=> $stable(cmp_shd)); // R9
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pre && upd_evt && cmp_wr) |=> (cmp_shd == $past(cmp_wdata))); // R10

endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
    parameter int CNT_W = 16,
    parameter int CMP_W = CNT_W + 1
) (
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CMP_W-1:0] cmp_shd,
    output logic             hit,
    output logic             below
);

    localparam int PAD_W = CMP_W - CNT_W;

    logic [CMP_W-1:0] cnt_ext;

    always_comb begin
        cnt_ext = {{PAD_W{1'b0}}, cnt_val};
        hit     = cnt_en && (cnt_ext == cmp_shd);
        below   = cnt_en && (cnt_ext < cmp_shd);
    end

    initial begin
        AST_WIDE_CMP: assert (CMP_W > CNT_W); // R12
    end

endmodule

// File: rtl/tcc_oref_gen.sv
module tcc_oref_gen
    import tcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_e mode,
    input  logic      cnt_en,
    input  logic      hit,
    input  logic      below,
    output logic      oref
);

    typedef struct packed {
        logic lvl;
    } oref_t;

    oref_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            OM_HOLD:  st_d.lvl = st_q.lvl;
            OM_CLR:   if (hit) st_d.lvl = 1'b0;
            OM_SET:   if (hit) st_d.lvl = 1'b1;
            OM_TGL:   if (hit) st_d.lvl = ~st_q.lvl;
            OM_LOW:   st_d.lvl = 1'b0;
            OM_HIGH:  st_d.lvl = 1'b1;
            OM_PWM_A: if (cnt_en) st_d.lvl = below;
            OM_PWM_B: if (cnt_en) st_d.lvl = ~below;
            default:  st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign oref = st_q.lvl;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_HOLD) |=> $stable(oref)); // R2
    AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_SET && hit) |=> oref); // R3
    AST_MATCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_CLR && hit) |=> !oref); // R3
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_TGL && hit) |=> (oref != $past(oref))); // R4
    AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_TGL && !hit) |=> $stable(oref)); // R4
    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_LOW) |=> !oref); // R5
    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_HIGH) |=> oref); // R5
    AST_PWM_A_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_PWM_A && cnt_en) |=> (oref == $past(below))); // R6
    AST_PWM_B_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_PWM_B && cnt_en) |=> (oref != $past(below))); // R7

endmodule

// File: rtl/tcc_top.sv
module tcc_top
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             upd_evt,
    input  logic             cmp_wr,
    input  logic [CNT_W:0]   cmp_wdata,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_preload,
    output logic [CNT_W:0]   cmp_rdata,
    output logic [CNT_W:0]   cmp_active,
    output logic             oref
);

    localparam int CMP_W = CNT_W + 1;

    out_mode_e mode;
    logic      hit;
    logic      below;

    tcc_cfg_regs #(
        .CMP_W (CMP_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_evt     (upd_evt),
        .cmp_wr      (cmp_wr),
        .cmp_wdata   (cmp_wdata),
        .cfg_wr      (cfg_wr),
        .cfg_mode    (cfg_mode),
        .cfg_preload (cfg_preload),
        .mode        (mode),
        .cmp_reg     (cmp_rdata),
        .cmp_shd     (cmp_active)
    );

    tcc_compare #(
        .CNT_W (CNT_W),
        .CMP_W (CMP_W)
    ) u_cmp (
        .cnt_en  (cnt_en),
        .cnt_val (cnt_val),
        .cmp_shd (cmp_active),
        .hit     (hit),
        .below   (below)
    );

    tcc_oref_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .cnt_en (cnt_en),
        .hit    (hit),
        .below  (below),
        .oref   (oref)
    );

    AST_MODE_CHANGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && mode == OM_HOLD) |=> $stable(oref)); // R11
    AST_PWM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_PWM_A && cnt_en && cmp_active == '0) |=> !oref); // R12

endmodule

// File: tb/tcc_top_tb.sv
module tcc_top_tb;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_en = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             upd_evt = 1'b0;
    logic             cmp_wr = 1'b0;
    logic [CNT_W:0]   cmp_wdata = '0;
    logic             cfg_wr = 1'b0;
    logic [2:0]       cfg_mode = 3'b000;
    logic             cfg_preload = 1'b0;
    logic [CNT_W:0]   cmp_rdata;
    logic [CNT_W:0]   cmp_active;
    logic             oref;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tcc_top #(.CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en      (cnt_en),
        .cnt_val     (cnt_val),
        .upd_evt     (upd_evt),
        .cmp_wr      (cmp_wr),
        .cmp_wdata   (cmp_wdata),
        .cfg_wr      (cfg_wr),
        .cfg_mode    (cfg_mode),
        .cfg_preload (cfg_preload),
        .cmp_rdata   (cmp_rdata),
        .cmp_active  (cmp_active),
        .oref        (oref)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int cnt, input bit en);
        @(negedge clk);
        cnt_val = cnt[CNT_W-1:0];
        cnt_en  = en;
        @(negedge clk);
        cnt_en  = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] m, input bit pre);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = m; cfg_preload = pre;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_cmp(input int v, input bit with_upd);
        @(negedge clk);
        cmp_wr = 1'b1; cmp_wdata = v[CNT_W:0]; upd_evt = with_upd;
        @(negedge clk);
        cmp_wr = 1'b0; upd_evt = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk);
        upd_evt = 1'b1;
        @(negedge clk);
        upd_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "oref", oref, 0);
        chk("R1", "cmp_rdata", cmp_rdata, 0);
        chk("R1", "cmp_active", cmp_active, 0);
        step(0, 1'b1);
        chk("R1", "oref hold after reset", oref, 0);
    endtask

    task automatic t_direct();
        wr_cmp(20, 1'b0);
        chk("R8", "active after direct write", cmp_active, 20);
        chk("R8", "rdata after direct write", cmp_rdata, 20);
    endtask

    task automatic t_match();
        set_cfg(3'b010, 1'b0);
        step(5, 1'b1);
        chk("R3", "set mode no match", oref, 0);
        step(20, 1'b0);
        chk("R3", "set mode match without enable", oref, 0);
        step(20, 1'b1);
        chk("R3", "set mode match", oref, 1);
        set_cfg(3'b001, 1'b0);
        chk("R11", "level kept on mode change", oref, 1);
        step(20, 1'b1);
        chk("R3", "clear mode match", oref, 0);
    endtask

    task automatic t_hold();
        set_cfg(3'b010, 1'b0);
        step(20, 1'b1);
        chk("R3", "set again", oref, 1);
        set_cfg(3'b000, 1'b0);
        step(20, 1'b1);
        chk("R2", "hold on match", oref, 1);
        step(5, 1'b1);
        chk("R2", "hold off match", oref, 1);
    endtask

    task automatic t_toggle();
        set_cfg(3'b011, 1'b0);
        step(20, 1'b1);
        chk("R4", "first toggle", oref, 0);
        step(20, 1'b1);
        chk("R4", "second toggle", oref, 1);
        step(20, 1'b0);
        chk("R4", "no toggle without enable", oref, 1);
        step(21, 1'b1);
        chk("R4", "no toggle off match", oref, 1);
    endtask

    task automatic t_force();
        set_cfg(3'b100, 1'b0);
        step(20, 1'b1);
        chk("R5", "forced low despite match", oref, 0);
        set_cfg(3'b101, 1'b0);
        step(7, 1'b0);
        chk("R5", "forced high without enable", oref, 1);
    endtask

    task automatic t_pwm();
        set_cfg(3'b110, 1'b0);
        chk("R11", "pwm entry keeps level", oref, 1);
        step(10, 1'b1);
        chk("R6", "pwm1 below", oref, 1);
        step(20, 1'b1);
        chk("R6", "pwm1 equal", oref, 0);
        step(25, 1'b1);
        chk("R6", "pwm1 above", oref, 0);
        step(10, 1'b0);
        chk("R6", "pwm1 no enable", oref, 0);
        set_cfg(3'b111, 1'b0);
        step(10, 1'b1);
        chk("R7", "pwm2 below", oref, 0);
        step(30, 1'b1);
        chk("R7", "pwm2 above", oref, 1);
        step(20, 1'b1);
        chk("R7", "pwm2 equal", oref, 1);
    endtask

    task automatic t_pwm_edges();
        set_cfg(3'b110, 1'b0);
        wr_cmp(0, 1'b0);
        step(0, 1'b1);
        chk("R12", "pwm1 zero at 0", oref, 0);
        step(128, 1'b1);
        chk("R12", "pwm1 zero at 128", oref, 0);
        step(255, 1'b1);
        chk("R12", "pwm1 zero at 255", oref, 0);
        wr_cmp(256, 1'b0);
        step(0, 1'b1);
        chk("R12", "pwm1 over max at 0", oref, 1);
        step(255, 1'b1);
        chk("R12", "pwm1 over max at 255", oref, 1);
        set_cfg(3'b111, 1'b0);
        step(255, 1'b1);
        chk("R12", "pwm2 over max at 255", oref, 0);
        wr_cmp(0, 1'b0);
        step(0, 1'b1);
        chk("R12", "pwm2 zero at 0", oref, 1);
        wr_cmp(256, 1'b0);
    endtask

    task automatic t_preload();
        set_cfg(3'b110, 1'b1);
        wr_cmp(50, 1'b0);
        chk("R9", "rdata updated", cmp_rdata, 50);
        chk("R9", "active held", cmp_active, 256);
        step(100, 1'b1);
        chk("R9", "old compare still used", oref, 1);
        pulse_upd();
        chk("R9", "active after update", cmp_active, 50);
        step(100, 1'b1);
        chk("R9", "new compare used", oref, 0);
    endtask

    task automatic t_same_cycle();
        wr_cmp(70, 1'b1);
        chk("R10", "active takes new write", cmp_active, 70);
        chk("R10", "rdata takes new write", cmp_rdata, 70);
        wr_cmp(90, 1'b0);
        chk("R10", "separate write held", cmp_active, 70);
        pulse_upd();
        chk("R10", "separate update loads", cmp_active, 90);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_match();
        t_hold();
        t_toggle();
        t_force();
        t_pwm();
        t_pwm_edges();
        t_preload();
        t_same_cycle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule